// File: doc/BRIEF.md
# Shared-Prefix Dual Tag Matcher

This block holds the address tag state of one physical cache way and compares a lookup tag against it. The way holds either one full-size block or two half-size blocks. It does not need a second full-width tag for the two-block case. Both residents share one stored high-order prefix, and each resident keeps only a few private low-order bits. A lookup reports a hit on the full-size resident, or on either half, in the same cycle as the lookup.

For the fill side, the block works out whether an incoming half-size block may join the resident already in the way. Pairing is allowed only when the way holds exactly one valid half-size block and the incoming tag has the same high prefix. A half-size fill that cannot pair clears the way and takes the lower half. A full-size fill always clears the way. Invalidation clears selected halves. Once both halves are invalid, the stored prefix is free to be reloaded. The data array, narrowness detection and replacement state are kept outside this block.

Top module: `shared_prefix_tag_way`

## Requirements
- R1: After reset, or after reset is asserted again in mid-run, every half and the full-size slot are invalid. hit_normal_o, hit_half_o and can_pair_o are all 0.
- R2: After a full-size fill with tag T, hit_normal_o is 1 only for a lookup equal to T in all TAG_W bits. A lookup that differs in any prefix bit or any low bit misses.
- R3: A half-size fill into an empty way loads the stored prefix from the fill tag and places the resident in half 0 (hit_half_o = 2'b01 for its tag).
- R4: can_pair_o is 1 exactly when the way is in two-block mode, exactly one half is valid, and the upper TAG_W-PRIV_W bits of fill_tag_i equal the stored prefix. It is 0 for an empty way, a full-size resident, a full pair, or a prefix mismatch. It does not depend on fill_en_i.
- R5: A half-size fill while can_pair_o is 1 writes only the private low bits of the free half and sets that half valid. The stored prefix and the other half are unchanged, and both halves then hit independently.
- R6: hit_half_o[h] is 1 only when half h is valid, the lookup prefix equals the stored prefix, and the lookup's low PRIV_W bits equal half h's private bits.
- R7: A half-size fill while can_pair_o is 0 evicts every resident and installs the new block alone in half 0, with its prefix.
- R8: A full-size fill evicts every resident, stores the whole tag, and leaves the way in one-block mode.
- R9: When inval_en_i is 1, each half whose inval_mask_i bit is 1 becomes invalid (bit h selects half h; bit 0 clears a full-size resident). With both halves invalid, the next half-size fill loads a new prefix.
- R10: When inval_en_i and fill_en_i are both 1 in the same cycle, the invalidation is applied and the fill is ignored.
- R11: hit_normal_o and hit_half_o are never 1 together. In one-block mode no half hit is reported, and in two-block mode no full-size hit is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_tag_i | input | TAG_W | Tag to compare against the way |
| hit_normal_o | output | 1 | Full-size resident matches the lookup |
| hit_half_o | output | 2 | Per-half match, bit h for half h |
| fill_en_i | input | 1 | Install fill_tag_i this cycle |
| fill_narrow_i | input | 1 | The fill is a half-size block |
| fill_tag_i | input | TAG_W | Tag of the incoming block, also used for the pairing test |
| can_pair_o | output | 1 | A half-size block with fill_tag_i may join the resident |
| inval_en_i | input | 1 | Apply inval_mask_i this cycle |
| inval_mask_i | input | 2 | Halves to invalidate |

## Verification
The bench builds the block with its defaults: TAG_W = 22 and PRIV_W = 2, which gives a 20-bit shared prefix. With only two private bits, all four low-bit values of one prefix can be cycled through. This exposes the cases where a lookup matches the prefix but not the half, or matches the low bits of the other half. Because prefixes are wide, two distinct prefixes are enough to drive the mismatch, eviction and prefix-reload paths on the same way.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int unsigned NUM_HALF = 2;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_NORMAL = 2'd1,
    ACT_NEW    = 2'd2,
    ACT_PAIR   = 2'd3
  } fill_act_e;
endpackage

// File: rtl/spt_fill_ctrl.sv
module spt_fill_ctrl
  import spt_pkg::*;
#(
  parameter int unsigned TAG_W    = 22,
  parameter int unsigned PRIV_W   = 2,
  localparam int unsigned PREFIX_W = TAG_W - PRIV_W
) (
  input  logic [NUM_HALF-1:0] valid_i,
  input  logic                width_i,
  input  logic [PREFIX_W-1:0] prefix_i,
  input  logic [TAG_W-1:0]    fill_tag_i,
  input  logic                fill_en_i,
  input  logic                fill_narrow_i,
  input  logic                inval_en_i,
  output logic                can_pair_o,
  output fill_act_e           act_o,
  output logic                free_half_o
);
  logic one_valid;
  logic prefix_eq;

  assign one_valid   = valid_i[0] ^ valid_i[1];
  assign prefix_eq   = (fill_tag_i[TAG_W-1:PRIV_W] == prefix_i);
  assign can_pair_o  = width_i & one_valid & prefix_eq;
  // free slot is the one not holding the single resident
  assign free_half_o = valid_i[0];

  always_comb begin
    act_o = ACT_NONE;
    if (fill_en_i && !inval_en_i) begin
      if (!fill_narrow_i)  act_o = ACT_NORMAL;
      else if (can_pair_o) act_o = ACT_PAIR;
      else                 act_o = ACT_NEW;
    end
  end
endmodule

// File: rtl/spt_way_store.sv
module spt_way_store
  import spt_pkg::*;
#(
  parameter int unsigned TAG_W    = 22,
  parameter int unsigned PRIV_W   = 2,
  localparam int unsigned PREFIX_W = TAG_W - PRIV_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fill_act_e           act_i,
  input  logic                free_half_i,
  input  logic [TAG_W-1:0]    fill_tag_i,
  input  logic                inval_en_i,
  input  logic [NUM_HALF-1:0] inval_mask_i,
  output logic [NUM_HALF-1:0] valid_o,
  output logic                width_o,
  output logic [PREFIX_W-1:0] prefix_o,
  output logic [NUM_HALF*PRIV_W-1:0] priv_o
);
  logic [NUM_HALF-1:0] valid_q;
  logic                width_q;
  logic [PREFIX_W-1:0] prefix_q;
  logic                evict;

  assign evict = (act_i == ACT_NORMAL) || (act_i == ACT_NEW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      width_q  <= 1'b0;
      prefix_q <= '0;
    end else if (inval_en_i) begin
      valid_q  <= valid_q & ~inval_mask_i;
    end else if (evict) begin
      valid_q  <= {{(NUM_HALF-1){1'b0}}, 1'b1};
      width_q  <= (act_i == ACT_NEW);
      prefix_q <= fill_tag_i[TAG_W-1:PRIV_W];
    end else if (act_i == ACT_PAIR) begin
      valid_q[free_half_i] <= 1'b1;
    end
  end

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_priv
    logic [PRIV_W-1:0] priv_q;
    logic              load;

    if (h == 0) begin : g_lo
      assign load = evict || ((act_i == ACT_PAIR) && !free_half_i);
    end else begin : g_hi
      assign load = (act_i == ACT_PAIR) && free_half_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 priv_q <= '0;
      else if (!inval_en_i && load) priv_q <= fill_tag_i[PRIV_W-1:0];
    end

    assign priv_o[h*PRIV_W +: PRIV_W] = priv_q;
  end

  assign valid_o  = valid_q;
  assign width_o  = width_q;
  assign prefix_o = prefix_q;
endmodule

// File: rtl/spt_half_cmp.sv
module spt_half_cmp #(
  parameter int unsigned PRIV_W = 2
) (
  input  logic              valid_i,
  input  logic              prefix_eq_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [PRIV_W-1:0] look_lo_i,
  output logic              match_o
);
  assign match_o = valid_i & prefix_eq_i & (priv_i == look_lo_i);
endmodule

// File: rtl/shared_prefix_tag_way.sv
module shared_prefix_tag_way
  import spt_pkg::*;
#(
  parameter int unsigned TAG_W  = 22,
  parameter int unsigned PRIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TAG_W-1:0]  lookup_tag_i,
  output logic              hit_normal_o,
  output logic [1:0]        hit_half_o,
  input  logic              fill_en_i,
  input  logic              fill_narrow_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  output logic              can_pair_o,
  input  logic              inval_en_i,
  input  logic [1:0]        inval_mask_i
);
  localparam int unsigned PREFIX_W = TAG_W - PRIV_W;

  logic [NUM_HALF-1:0]        valid_q;
  logic                       width_q;
  logic [PREFIX_W-1:0]        prefix_q;
  logic [NUM_HALF*PRIV_W-1:0] priv_q;
  fill_act_e                  act;
  logic                       free_half;
  logic                       look_prefix_eq;
  logic [NUM_HALF-1:0]        raw_match;

  spt_fill_ctrl #(.TAG_W(TAG_W), .PRIV_W(PRIV_W)) u_ctrl (
    .valid_i       (valid_q),
    .width_i       (width_q),
    .prefix_i      (prefix_q),
    .fill_tag_i    (fill_tag_i),
    .fill_en_i     (fill_en_i),
    .fill_narrow_i (fill_narrow_i),
    .inval_en_i    (inval_en_i),
    .can_pair_o    (can_pair_o),
    .act_o         (act),
    .free_half_o   (free_half)
  );

  spt_way_store #(.TAG_W(TAG_W), .PRIV_W(PRIV_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_i        (act),
    .free_half_i  (free_half),
    .fill_tag_i   (fill_tag_i),
    .inval_en_i   (inval_en_i),
    .inval_mask_i (inval_mask_i),
    .valid_o      (valid_q),
    .width_o      (width_q),
    .prefix_o     (prefix_q),
    .priv_o       (priv_q)
  );

  assign look_prefix_eq = (lookup_tag_i[TAG_W-1:PRIV_W] == prefix_q);

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_cmp
    spt_half_cmp #(.PRIV_W(PRIV_W)) u_cmp (
      .valid_i     (valid_q[h]),
      .prefix_eq_i (look_prefix_eq),
      .priv_i      (priv_q[h*PRIV_W +: PRIV_W]),
      .look_lo_i   (lookup_tag_i[PRIV_W-1:0]),
      .match_o     (raw_match[h])
    );
  end

  // one-block mode: half 0 slot plus prefix form the whole tag
  assign hit_normal_o = ~width_q & raw_match[0];
  assign hit_half_o   = width_q ? raw_match : 2'b00;
endmodule

// File: rtl/spt_way_chk.sv
module spt_way_chk #(
  parameter int unsigned PREFIX_W = 20
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fill_en_i,
  input logic                fill_narrow_i,
  input logic                inval_en_i,
  input logic [1:0]          inval_mask_i,
  input logic                can_pair_o,
  input logic                hit_normal_o,
  input logic [1:0]          hit_half_o,
  input logic [1:0]          valid_q,
  input logic                width_q,
  input logic [PREFIX_W-1:0] prefix_q
);
  p_hit_exclusive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_normal_o && (hit_half_o != 2'b00)));

  p_pair_one_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    can_pair_o |-> (width_q && $countones(valid_q) == 1));

  p_prefix_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((valid_q != 2'b00) && !fill_en_i) |=> $stable(prefix_q));

  p_pair_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && fill_narrow_i && can_pair_o && !inval_en_i)
      |=> ($stable(prefix_q) && valid_q == 2'b11));

  p_inval_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_en_i |=> ((valid_q & $past(inval_mask_i)) == 2'b00));

  p_normal_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !fill_narrow_i && !inval_en_i) |=> (!width_q && valid_q == 2'b01));

  p_no_pair_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && fill_narrow_i && !can_pair_o && !inval_en_i)
      |=> (width_q && valid_q == 2'b01));
endmodule

bind shared_prefix_tag_way spt_way_chk #(.PREFIX_W(PREFIX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fill_en_i     (fill_en_i),
  .fill_narrow_i (fill_narrow_i),
  .inval_en_i    (inval_en_i),
  .inval_mask_i  (inval_mask_i),
  .can_pair_o    (can_pair_o),
  .hit_normal_o  (hit_normal_o),
  .hit_half_o    (hit_half_o),
  .valid_q       (valid_q),
  .width_q       (width_q),
  .prefix_q      (prefix_q)
);

// File: tb/shared_prefix_tag_way_tb.sv
`timescale 1ns/1ps
module shared_prefix_tag_way_tb;
  localparam int unsigned TAG_W  = 22;
  localparam int unsigned PRIV_W = 2;
  localparam logic [19:0] PA = 20'h3A5C1;
  localparam logic [19:0] PB = 20'h0F0F0;

  // op: 0 idle, 1 full-size fill, 2 half-size fill, 3 invalidate
  typedef struct packed {
    logic [1:0]       op;
    logic [TAG_W-1:0] tag;
    logic [1:0]       mask;
    logic [TAG_W-1:0] look;
    logic [TAG_W-1:0] probe;
    logic             e_hn;
    logic [1:0]       e_hh;
    logic             e_cp;
    logic [3:0]       req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd2, {PA,2'b01}, 2'b00, {PA,2'b01}, {PA,2'b10}, 1'b0, 2'b01, 1'b1, 4'd3},  // R3 first half-size fill
    '{2'd0, '0,         2'b00, {PA,2'b10}, {PB,2'b10}, 1'b0, 2'b00, 1'b0, 4'd4},  // R4 prefix mismatch, R6 empty half
    '{2'd2, {PA,2'b10}, 2'b00, {PA,2'b10}, {PA,2'b11}, 1'b0, 2'b10, 1'b0, 4'd5},  // R5 pair into half 1
    '{2'd0, '0,         2'b00, {PA,2'b01}, {PA,2'b00}, 1'b0, 2'b01, 1'b0, 4'd5},  // R5 half 0 kept
    '{2'd0, '0,         2'b00, {PB,2'b01}, {PA,2'b00}, 1'b0, 2'b00, 1'b0, 4'd6},  // R6 prefix mismatch
    '{2'd0, '0,         2'b00, {PA,2'b11}, {PA,2'b00}, 1'b0, 2'b00, 1'b0, 4'd6},  // R6 low bits mismatch
    '{2'd3, '0,         2'b01, {PA,2'b01}, {PA,2'b00}, 1'b0, 2'b00, 1'b1, 4'd9},  // R9 half 0 cleared
    '{2'd2, {PA,2'b00}, 2'b00, {PA,2'b00}, {PA,2'b11}, 1'b0, 2'b01, 1'b0, 4'd5},  // R5 refill free half 0
    '{2'd2, {PB,2'b11}, 2'b00, {PB,2'b11}, {PA,2'b10}, 1'b0, 2'b01, 1'b0, 4'd7},  // R7 full pair evicted
    '{2'd0, '0,         2'b00, {PA,2'b10}, {PB,2'b00}, 1'b0, 2'b00, 1'b1, 4'd7},  // R7 old residents gone
    '{2'd1, {PB,2'b10}, 2'b00, {PB,2'b10}, {PB,2'b01}, 1'b1, 2'b00, 1'b0, 4'd8},  // R8 full-size fill, R11
    '{2'd0, '0,         2'b00, {PB,2'b11}, {PB,2'b01}, 1'b0, 2'b00, 1'b0, 4'd2},  // R2 low bit differs
    '{2'd0, '0,         2'b00, {PB^20'h1,2'b10}, '0,   1'b0, 2'b00, 1'b0, 4'd2},  // R2 prefix bit differs
    '{2'd2, {PA,2'b01}, 2'b00, {PB,2'b10}, {PA,2'b10}, 1'b0, 2'b00, 1'b1, 4'd7},  // R7 half-size evicts full-size
    '{2'd3, '0,         2'b11, {PA,2'b01}, {PA,2'b10}, 1'b0, 2'b00, 1'b0, 4'd9},  // R9 way emptied
    '{2'd2, {PB,2'b00}, 2'b00, {PB,2'b00}, {PB,2'b01}, 1'b0, 2'b01, 1'b1, 4'd9}   // R9 new prefix loaded
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [TAG_W-1:0] lookup_tag_i = '0;
  logic             hit_normal_o;
  logic [1:0]       hit_half_o;
  logic             fill_en_i = 1'b0;
  logic             fill_narrow_i = 1'b0;
  logic [TAG_W-1:0] fill_tag_i = '0;
  logic             can_pair_o;
  logic             inval_en_i = 1'b0;
  logic [1:0]       inval_mask_i = '0;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  shared_prefix_tag_way #(.TAG_W(TAG_W), .PRIV_W(PRIV_W)) u_dut (
    .clk_i, .rst_ni, .lookup_tag_i, .hit_normal_o, .hit_half_o,
    .fill_en_i, .fill_narrow_i, .fill_tag_i, .can_pair_o,
    .inval_en_i, .inval_mask_i
  );

  task automatic check(input string req, input logic e_hn, input logic [1:0] e_hh,
                       input logic e_cp);
    n_run++;
    if (hit_normal_o !== e_hn || hit_half_o !== e_hh || can_pair_o !== e_cp) begin
      n_fail++;
      $display("FAIL %s: got hn=%b hh=%b cp=%b, expected hn=%b hh=%b cp=%b",
               req, hit_normal_o, hit_half_o, can_pair_o, e_hn, e_hh, e_cp);
    end
  endtask

  // drive one operation for one cycle, then set lookup/probe for sampling at the next negedge
  task automatic step(input logic [1:0] op, input logic [TAG_W-1:0] tag,
                      input logic [1:0] mask, input logic [TAG_W-1:0] look,
                      input logic [TAG_W-1:0] probe);
    fill_en_i     = (op == 2'd1) || (op == 2'd2);
    fill_narrow_i = (op == 2'd2);
    fill_tag_i    = tag;
    inval_en_i    = (op == 2'd3);
    inval_mask_i  = mask;
    @(posedge clk_i);
    #1;
    fill_en_i    = 1'b0;
    inval_en_i   = 1'b0;
    fill_tag_i   = probe;
    lookup_tag_i = look;
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    lookup_tag_i = '0;
    fill_tag_i   = {PA,2'b00};
    repeat (3) @(negedge clk_i);
    check("R1 reset held", 1'b0, 2'b00, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", 1'b0, 2'b00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].tag, VECS[i].mask, VECS[i].look, VECS[i].probe);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].e_hn, VECS[i].e_hh, VECS[i].e_cp);
    end

    // R10: invalidate and fill together; only the invalidate applies
    fill_en_i     = 1'b1;
    fill_narrow_i = 1'b1;
    fill_tag_i    = {PA,2'b11};
    inval_en_i    = 1'b1;
    inval_mask_i  = 2'b01;
    @(posedge clk_i);
    #1;
    fill_en_i    = 1'b0;
    inval_en_i   = 1'b0;
    lookup_tag_i = {PA,2'b11};
    fill_tag_i   = {PA,2'b10};
    @(negedge clk_i);
    check("R10 fill dropped", 1'b0, 2'b00, 1'b0);
    lookup_tag_i = {PB,2'b00};
    #0.5;
    check("R10 resident cleared", 1'b0, 2'b00, 1'b0);

    // R11: full-size resident never shows half hits even with matching low bits
    step(2'd1, {PA,2'b00}, 2'b00, {PA,2'b00}, {PA,2'b01});
    check("R11 one-block mode", 1'b1, 2'b00, 1'b0);

    // R1: reset in mid-run clears the way
    step(2'd2, {PB,2'b01}, 2'b00, {PB,2'b01}, {PB,2'b10});
    check("R3 narrow after normal", 1'b0, 2'b01, 1'b1);
    rst_ni = 1'b0;
    #0.5;
    check("R1 mid-run reset", 1'b0, 2'b00, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after mid-run reset", 1'b0, 2'b00, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule